// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

A synthesizable behavioural model of a single-port synchronous static RAM whose inputs and outputs are both registered. Each word is 36 bits wide, split into four 9-bit byte lanes. Every rising clock edge captures the address, the write data, the chip selects and the write controls. A new access or burst starts only on a cycle where one of two active-low address strobes is asserted. The processor strobe always opens with a read. The controller strobe opens with a read or a write, chosen by the write controls.

After a burst has started, each cycle with the active-low advance input asserted steps a 2-bit counter. That counter forms the next address inside the four-word group, in either a linear or an interleaved order. Read data reaches the outputs two clocks after the address is latched. After that, burst beats follow one per clock.

The output drive enable is pipelined. When a burst is ended by a deselect, the enable stays on for one extra cycle. This lets several devices share a data bus with no turnaround wait. An asynchronous active-low output enable gates the drive combinationally.

Top module: `pbs_sram`

## Requirements
- R1: After synchronous reset, `dq_drive` is 0 and `dq_out` is all zeros.
- R2: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe cycle that finds any other combination is a deselect. It performs no access, ends the current burst and writes nothing.
- R3: A read latched at edge k has its word on `dq_out` after edge k+2. A write latched at one edge, followed by a read of the same address at the next edge, returns the new word.
- R4: A cycle with `ctrl_stb_n`=0 and `proc_stb_n`=1 writes at the latched address in that same cycle when the write controls qualify. Otherwise it reads.
- R5: A cycle with `proc_stb_n`=0 is always a read, whatever the write controls are. This includes the case where both strobes are low.
- R6: With `all_wr_n`=0, a write updates all four lanes, whatever `lane_wr_en_n` and `lane_we_n` are.
- R7: With `all_wr_n`=1 and `lane_wr_en_n`=0, each bit i of `lane_we_n` that is 0 writes only lane i, which is data bits 9i+8 down to 9i. With `lane_wr_en_n`=1 and `all_wr_n`=1, the cycle is not a write.
- R8: With `burst_lin`=1, beat c (c = 0..3) of a burst accesses the address whose two low bits are (base + c) mod 4. The upper address bits stay those of the base.
- R9: With `burst_lin`=0, beat c accesses the address whose two low bits are base XOR c. The upper bits stay those of the base.
- R10: An advance cycle inside an active burst writes when the write controls qualify and reads otherwise. So a burst opened by the processor strobe writes on its later beats.
- R11: A cycle with both strobes high and `adv_n`=1 performs no access. An advance while no burst is active performs no access. When a read stream ends this way, `dq_drive` falls right after the last data beat.
- R12: When a deselect follows a read stream, `dq_drive` stays 1 for one extra cycle after the last beat, holding that beat's data, and then falls.
- R13: `oe_n`=1 forces `dq_drive` to 0 and `dq_out` to zero in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, latched on a strobe cycle |
| proc_stb_n | input | 1 | Processor address strobe, active low, read-first |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_en_n | input | 1 | Lane write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| wdata | input | LANES*LANE_W | Write data |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_drive | output | 1 | Output driver enable |

## Verification
The bench builds the block with ADDR_W=7, LANES=4 and LANE_W=9. This gives a 128-word array that the bench can fill completely and check against its own model. The narrow address lets a linear burst run in the top group, 0x7C to 0x7F, so wrap-around is checked with all upper address bits at one. The four 9-bit lanes keep the lane boundaries on bit positions that are not multiples of eight, so a misplaced lane slice shows up in the merged word.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  parameter int unsigned BURST_W = 2;

  // Low address bits of a burst beat: linear adds, interleaved XORs.
  function automatic logic [BURST_W-1:0] burst_lo(input logic [BURST_W-1:0] base,
                                                  input logic [BURST_W-1:0] cnt,
                                                  input logic lin);
    burst_lo = lin ? (base + cnt) : (base ^ cnt);
  endfunction
endpackage

// File: rtl/pbs_ctrl.sv
module pbs_ctrl #(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              burst_lin,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic              acc_dsel,
  output logic [LANES-1:0]  acc_mask,
  output logic [DATA_W-1:0] acc_wdata
);
  localparam int BW = pbs_pkg::BURST_W;

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [BW-1:0]     cnt;

  logic              start_c, sel_c, wq_c;
  logic [LANES-1:0]  mask_c;
  logic [BW-1:0]     cnt_nxt;
  logic [ADDR_W-1:0] adv_addr;

  always_comb begin
    start_c  = !proc_stb_n || !ctrl_stb_n;
    sel_c    = !sel_a_n && sel_b && !sel_c_n;
    if (!all_wr_n)          mask_c = '1;
    else if (!lane_wr_en_n) mask_c = ~lane_we_n;
    else                    mask_c = '0;
    wq_c     = |mask_c;
    cnt_nxt  = cnt + 1'b1;
    adv_addr = {base[ADDR_W-1:BW], pbs_pkg::burst_lo(base[BW-1:0], cnt_nxt, burst_lin)};
  end

  always_ff @(posedge clk) begin
    acc_mask  <= mask_c;
    acc_wdata <= wdata;
    if (rst) begin
      active   <= 1'b0;
      base     <= '0;
      cnt      <= '0;
      acc_addr <= '0;
      acc_rd   <= 1'b0;
      acc_wr   <= 1'b0;
      acc_dsel <= 1'b0;
    end else if (start_c) begin
      if (sel_c) begin
        active   <= 1'b1;
        base     <= addr_i;
        cnt      <= '0;
        acc_addr <= addr_i;
        acc_rd   <= !proc_stb_n || !wq_c;
        acc_wr   <= proc_stb_n && wq_c;
        acc_dsel <= 1'b0;
      end else begin
        active   <= 1'b0;
        acc_rd   <= 1'b0;
        acc_wr   <= 1'b0;
        acc_dsel <= 1'b1;
      end
    end else if (!adv_n && active) begin
      cnt      <= cnt_nxt;
      acc_addr <= adv_addr;
      acc_rd   <= !wq_c;
      acc_wr   <= wq_c;
      acc_dsel <= 1'b0;
    end else begin
      acc_rd   <= 1'b0;
      acc_wr   <= 1'b0;
      acc_dsel <= 1'b0;
    end
  end
endmodule

// File: rtl/pbs_array.sv
module pbs_array #(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [LANES-1:0]  acc_mask,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_q
);
  // One simple-port RAM per lane so each maps to its own block RAM.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (acc_wr && acc_mask[g])
        mem[acc_addr] <= acc_wdata[g*LANE_W +: LANE_W];
      if (acc_rd)
        rd_q[g*LANE_W +: LANE_W] <= mem[acc_addr];
    end
  end
endmodule

// File: rtl/pbs_outpipe.sv
module pbs_outpipe #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_rd,
  input  logic              acc_dsel,
  input  logic [DATA_W-1:0] rd_q,
  input  logic              oe_n,
  output logic              m_rd,
  output logic              q_valid,
  output logic              q_tail,
  output logic [DATA_W-1:0] q_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  logic m_dsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rd    <= 1'b0;
      m_dsel  <= 1'b0;
      q_valid <= 1'b0;
      q_tail  <= 1'b0;
      q_data  <= '0;
    end else begin
      m_rd    <= acc_rd;
      m_dsel  <= acc_dsel;
      q_valid <= m_rd;
      // Extra drive cycle only when a deselect ends a driven stream.
      q_tail  <= m_dsel && q_valid;
      if (m_rd) q_data <= rd_q;
    end
  end

  always_comb begin
    dq_drive = (q_valid || q_tail) && !oe_n;
    dq_out   = dq_drive ? q_data : '0;
  end
endmodule

// File: rtl/pbs_sram.sv
module pbs_sram #(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              burst_lin,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_rd, acc_wr, acc_dsel;
  logic [LANES-1:0]  acc_mask;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] rd_q;
  logic              m_rd, q_valid, q_tail;
  logic [DATA_W-1:0] q_data;

  pbs_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) ctrl_i (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_we_n(lane_we_n),
    .wdata(wdata), .burst_lin(burst_lin),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_dsel(acc_dsel),
    .acc_mask(acc_mask), .acc_wdata(acc_wdata)
  );

  pbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_mask(acc_mask), .acc_wdata(acc_wdata), .rd_q(rd_q)
  );

  pbs_outpipe #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_dsel(acc_dsel), .rd_q(rd_q),
    .oe_n(oe_n), .m_rd(m_rd), .q_valid(q_valid), .q_tail(q_tail),
    .q_data(q_data), .dq_out(dq_out), .dq_drive(dq_drive)
  );
endmodule

// File: rtl/pbs_sram_chk.sv
module pbs_sram_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              adv_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              all_wr_n,
  input logic              lane_wr_en_n,
  input logic [LANES-1:0]  lane_we_n,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic              m_rd,
  input logic              q_valid,
  input logic              q_tail,
  input logic [DATA_W-1:0] q_data
);
  logic sel_ok, wr_ok, stb;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
  assign wr_ok  = !all_wr_n || (!lane_wr_en_n && (lane_we_n != '1));
  assign stb    = !proc_stb_n || !ctrl_stb_n;

  a_r2_deselect_idle: assert property (@(posedge clk) disable iff (rst)
    (stb && !sel_ok) |=> (!acc_rd && !acc_wr));
  a_r5_proc_reads: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && sel_ok) |=> (acc_rd && !acc_wr));
  a_r4_ctrl_writes: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && !ctrl_stb_n && sel_ok && wr_ok) |=> acc_wr);
  a_r11_no_access: assert property (@(posedge clk) disable iff (rst)
    (!stb && adv_n) |=> (!acc_rd && !acc_wr));
  a_r3_read_reaches_out: assert property (@(posedge clk) disable iff (rst)
    m_rd |=> q_valid);
  a_r12_tail_after_valid: assert property (@(posedge clk) disable iff (rst)
    q_tail |-> $past(q_valid));
  a_r12_tail_one_cycle: assert property (@(posedge clk) disable iff (rst)
    q_tail |=> !q_tail);
  a_r12_tail_holds_data: assert property (@(posedge clk) disable iff (rst)
    q_tail |-> $stable(q_data));
endmodule

bind pbs_sram pbs_sram_chk #(.LANES(LANES), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
  .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_we_n(lane_we_n),
  .acc_rd(acc_rd), .acc_wr(acc_wr), .m_rd(m_rd), .q_valid(q_valid),
  .q_tail(q_tail), .q_data(q_data)
);

// File: tb/pbs_sram_tb_top.sv
`timescale 1ns/1ps
module pbs_sram_tb_top;
  localparam int AW = 7, LN = 4, LW = 9, DW = LN * LW;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] addr_i;
  logic proc_stb_n, ctrl_stb_n, adv_n, sel_a_n, sel_b, sel_c_n;
  logic all_wr_n, lane_wr_en_n, burst_lin, oe_n;
  logic [LN-1:0] lane_we_n;
  logic [DW-1:0] wdata, dq_out;
  logic dq_drive;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [DW-1:0] model [1 << AW];

  always #4 clk = ~clk;

  pbs_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_we_n(lane_we_n), .wdata(wdata), .burst_lin(burst_lin), .oe_n(oe_n),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  function automatic logic [DW-1:0] pat(input int a);
    pat = 36'h9_0000_0000 | (DW'(a) * 36'h0_0001_0003);
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    all_wr_n = 1; lane_wr_en_n = 1; lane_we_n = '1;
    oe_n = 0; wdata = '0; addr_i = '0;
  endtask

  task automatic wr_word(input int a, input logic [DW-1:0] d);
    ctrl_stb_n = 0; addr_i = AW'(a); all_wr_n = 0; wdata = d;
    step(); idle();
    model[a] = d;
  endtask

  task automatic rd_word(input int a, input string tag);
    ctrl_stb_n = 0; addr_i = AW'(a);
    step(); idle(); step(); step();
    chk(DW'(dq_drive), 1, {tag, " drive"});
    chk(dq_out, model[a], tag);
  endtask

  task automatic t_reset();
    chk(DW'(dq_drive), 0, "R1 drive after reset");
    chk(dq_out, '0, "R1 data after reset");
  endtask

  task automatic t_write_read();
    wr_word(16, 36'h1_2345_6789);
    rd_word(16, "R4 controller write then read");
    // back-to-back write then read of same address
    ctrl_stb_n = 0; addr_i = 17; all_wr_n = 0; wdata = 36'hE_DCBA_9876;
    step(); idle(); ctrl_stb_n = 0; addr_i = 17;
    model[17] = 36'hE_DCBA_9876;
    step(); idle(); step(); step();
    chk(dq_out, model[17], "R3 write followed by read same address");
  endtask

  task automatic t_lanes();
    logic [DW-1:0] d;
    wr_word(18, 36'h0_0000_0000);
    d = 36'hF_FFFF_FFFF;
    ctrl_stb_n = 0; addr_i = 18; lane_wr_en_n = 0; lane_we_n = 4'b1010; wdata = d;
    step(); idle();
    model[18] = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    rd_word(18, "R7 lanes 0 and 2 written");
    ctrl_stb_n = 0; addr_i = 18; lane_wr_en_n = 1; lane_we_n = 4'b0000; wdata = 36'h5_5555_5555;
    step(); idle(); step(); step();
    rd_word(18, "R7 lane strobes without qualifier ignored");
    ctrl_stb_n = 0; addr_i = 18; all_wr_n = 0; lane_wr_en_n = 1; lane_we_n = '1;
    wdata = 36'hA_BCDE_F012;
    step(); idle();
    model[18] = 36'hA_BCDE_F012;
    rd_word(18, "R6 global write overrides lanes");
  endtask

  task automatic t_proc();
    burst_lin = 1;
    proc_stb_n = 0; addr_i = 32; all_wr_n = 0; wdata = 36'h3_3333_3333;
    step(); proc_stb_n = 1; adv_n = 0; all_wr_n = 0; wdata = 36'h7_7777_7777;
    step(); idle(); step(); step();
    model[33] = 36'h7_7777_7777;
    rd_word(32, "R5 processor strobe ignores write controls");
    rd_word(33, "R10 advance beat writes");
    proc_stb_n = 0; ctrl_stb_n = 0; addr_i = 34; all_wr_n = 0; wdata = 36'h1_1111_1111;
    step(); idle(); step(); step();
    chk(dq_out, model[34], "R5 both strobes give read data");
    rd_word(34, "R5 both strobes no write");
  endtask

  task automatic t_burst(input int base, input logic lin, input string tag);
    logic [DW-1:0] got [4];
    burst_lin = lin;
    ctrl_stb_n = 0; addr_i = AW'(base);
    step(); idle(); adv_n = 0;
    step(); step(); got[0] = dq_out;
    step(); idle(); got[1] = dq_out;
    step(); got[2] = dq_out;
    step(); got[3] = dq_out;
    for (int c = 0; c < 4; c++) begin
      int lo, a;
      lo = lin ? ((base + c) % 4) : ((base % 4) ^ c);
      a  = (base & ~3) | lo;
      chk(got[c], model[a], $sformatf("%s beat %0d", tag, c));
    end
  endtask

  task automatic t_dcd();
    ctrl_stb_n = 0; addr_i = 48;
    step(); idle(); ctrl_stb_n = 0; sel_a_n = 1;
    step(); idle(); step();
    chk(DW'(dq_drive), 1, "R12 last beat driven");
    step();
    chk(DW'(dq_drive), 1, "R12 extra drive cycle after deselect");
    chk(dq_out, model[48], "R12 data held in extra cycle");
    step();
    chk(DW'(dq_drive), 0, "R12 drive off after extra cycle");
    ctrl_stb_n = 0; addr_i = 48;
    step(); idle(); step(); step();
    chk(DW'(dq_drive), 1, "R11 beat driven");
    step();
    chk(DW'(dq_drive), 0, "R11 idle end drops drive at once");
  endtask

  task automatic t_select();
    for (int k = 0; k < 3; k++) begin
      ctrl_stb_n = 0; addr_i = 49; all_wr_n = 0; wdata = 36'h0_DEAD_0000;
      sel_a_n = (k == 0); sel_b = (k != 1); sel_c_n = (k == 2);
      step(); idle();
      rd_word(49, $sformatf("R2 select combo %0d blocks write", k));
    end
    ctrl_stb_n = 0; sel_b = 0; addr_i = 49;
    step(); idle(); adv_n = 0; all_wr_n = 0; wdata = 36'h0_BAD0_0000;
    step(); idle(); all_wr_n = 0; wdata = 36'h0_BAD1_0000;
    step(); idle(); step();
    rd_word(50, "R11 advance after deselect writes nothing");
    rd_word(49, "R11 idle with write controls writes nothing");
  endtask

  task automatic t_oe();
    ctrl_stb_n = 0; addr_i = 50;
    step(); idle(); step(); step();
    oe_n = 1; #1;
    chk(DW'(dq_drive), 0, "R13 oe high drive off");
    chk(dq_out, '0, "R13 oe high data zero");
    oe_n = 0; #1;
    chk(dq_out, model[50], "R13 oe low data back");
  endtask

  initial begin
    idle(); burst_lin = 1;
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    for (int a = 0; a < (1 << AW); a++) wr_word(a, pat(a));
    step(); step();
    t_write_read();
    t_lanes();
    t_proc();
    t_burst(126, 1'b1, "R8 linear top group");
    t_burst(65, 1'b0, "R9 interleaved");
    t_burst(66, 1'b1, "R8 linear mid group");
    t_dcd();
    t_select();
    t_oe();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule